// File: doc/BRIEF.md
# Memory-Mapped Serial Port With Status Flags

This block is a serial transmitter and receiver that a processor reaches through a small synchronous register port. The port is selected by a 3-bit word address and has five locations: received character, character to send, status, interrupt enables and bit-period divisor. Each line frame has one low start bit, eight data bits sent least significant bit first, no parity bit and two high stop bits. The divisor gives the number of clock cycles per bit. Its reset value is a parameter; the intended rate is 115200 baud.

A write to the transmit location places a character in a one-entry holding register, which feeds a shift register. The receiver passes the line through two flops and starts a frame on a falling edge. It samples each bit at the middle of its period, counting in divisor ticks. The status word has nine bits: bit0 PE, bit1 FE, bit2 BRK, bit3 ROE, bit4 TOE, bit5 TMT, bit6 TRDY, bit7 RRDY, bit8 E. The interrupt-enable word uses the same bit positions. The interrupt line is high when any status bit and its enable bit are both set.

Software clears all error flags at once by writing the status location with any value. Reading the received character clears the ready flag. The divisor location can be made writable or constant through a parameter.

Top module: `sio_uart_mm`

## Requirements
- R1: After reset, status reads 0x060 (TRDY and TMT set), the enable word reads 0, the divisor reads DEF_DIV, txd is high and irq is low.
- R2: A write to offset 1 while TRDY is high sends one frame on txd. The frame is a low start bit, the eight data bits least significant bit first, and two high stop bits, each lasting divisor clock cycles. TMT (bit5) stays low until the frame ends and then returns high, with txd high.
- R3: A write to offset 1 while TRDY (bit6) is low sets TOE (bit4) and E (bit8), and the written character is never sent.
- R4: A frame received on rxd sets RRDY (bit7), and its data byte reads back in bits 7:0 of offset 0.
- R5: A read of offset 0 clears RRDY.
- R6: A character that completes while RRDY is still set sets ROE (bit3) and E, and offset 0 then holds the newer character.
- R7: A received frame with either stop bit low sets FE (bit1) and E.
- R8: rxd held low for a whole frame, stop bits included, sets BRK (bit2), FE and E, and delivers a character of 0x00.
- R9: Any write to offset 2 clears E, TOE, ROE, BRK, FE and PE, whatever the data, and leaves RRDY, TRDY and TMT as they were.
- R10: Offset 3 stores wdata[8:0] and reads it back; irq is high exactly when some status bit and its enable bit in offset 3 are both set.
- R11: Offset 4 holds the divisor, the number of clock cycles per line bit. It reads back the written value, and values below 4 act as 4.
- R12: PE (bit0) always reads 0, since the frame has no parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe; its side effects occur at the clock edge |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data for addr, combinational |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker checks the flag rules on every cycle:
- a write to a busy transmitter must set TOE;
- a status write must leave every error flag clear;
- a read of the received character must drop RRDY;
- a character completing over an unread one must set ROE;
- the line must be high whenever TMT is set;
- irq must stay low while all enable bits are zero.

Only the bench's scenarios show the serial behaviour. The scoreboard decodes transmitted frames bit by bit, and the bench checks mid-bit reception, break and framing detection on crafted rxd waveforms, and that the discarded character never appears on the line.

// File: rtl/sio_pkg.sv
package sio_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] REG_RXD  = 3'd0;
   localparam logic [ADDR_W-1:0] REG_TXD  = 3'd1;
   localparam logic [ADDR_W-1:0] REG_STAT = 3'd2;
   localparam logic [ADDR_W-1:0] REG_CTRL = 3'd3;
   localparam logic [ADDR_W-1:0] REG_DIV  = 3'd4;

   // status and enable bit positions
   localparam int NFLAG  = 9;
   localparam int F_PE   = 0;
   localparam int F_FE   = 1;
   localparam int F_BRK  = 2;
   localparam int F_ROE  = 3;
   localparam int F_TOE  = 4;
   localparam int F_TMT  = 5;
   localparam int F_TRDY = 6;
   localparam int F_RRDY = 7;
   localparam int F_E    = 8;

   localparam int MIN_DIV = 4;

   typedef enum logic [1:0] {RX_IDLE, RX_RUN} rx_state_e;
endpackage

// File: rtl/sio_tx.sv
module sio_tx #(
   parameter int DATA_W = 8,
   parameter int STOP_W = 2,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   output logic              hold_empty,
   output logic              idle,
   output logic              txd
);
   localparam int FRAME_W = 1 + DATA_W + STOP_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic [DATA_W-1:0]  hold_q;
   logic               hold_full_q;
   logic [FRAME_W-1:0] shift_q;
   logic [CNT_W-1:0]   bits_left_q;
   logic [DIV_W-1:0]   tick_q;
   logic               busy;

   assign busy = (bits_left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         shift_q     <= '1;
         bits_left_q <= '0;
         tick_q      <= '0;
      end else begin
         if (load) begin
            hold_q      <= ld_data;
            hold_full_q <= 1'b1;
         end
         if (!busy && hold_full_q) begin
            shift_q     <= {{STOP_W{1'b1}}, hold_q, 1'b0};
            bits_left_q <= CNT_W'(FRAME_W);
            tick_q      <= div - 1'b1;
            hold_full_q <= 1'b0;
         end else if (busy) begin
            if (tick_q == '0) begin
               shift_q     <= {1'b1, shift_q[FRAME_W-1:1]};
               bits_left_q <= bits_left_q - 1'b1;
               tick_q      <= div - 1'b1;
            end else begin
               tick_q <= tick_q - 1'b1;
            end
         end
      end
   end

   assign hold_empty = !hold_full_q;
   assign idle       = !hold_full_q && !busy;
   assign txd        = shift_q[0];
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
   parameter int DATA_W = 8,
   parameter int STOP_W = 2,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div,
   input  logic              rxd,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              ferr,
   output logic              brk
);
   import sio_pkg::*;
   localparam int FRAME_W = 1 + DATA_W + STOP_W;
   localparam int CNT_W   = $clog2(FRAME_W);

   logic [1:0]         sync_q;
   logic               prev_q;
   rx_state_e          state_q;
   logic [DIV_W-1:0]   tick_q;
   logic [CNT_W-1:0]   idx_q;
   logic [FRAME_W-1:0] shreg_q;
   logic               line;
   logic               last_bit;
   logic [FRAME_W-1:0] frame_w;

   always_comb begin
      line     = sync_q[1];
      frame_w  = {line, shreg_q[FRAME_W-1:1]};
      last_bit = (idx_q == CNT_W'(FRAME_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= '1;
         prev_q  <= 1'b1;
         state_q <= RX_IDLE;
         tick_q  <= '0;
         idx_q   <= '0;
         shreg_q <= '0;
         done    <= 1'b0;
         data    <= '0;
         ferr    <= 1'b0;
         brk     <= 1'b0;
      end else begin
         sync_q <= {sync_q[0], rxd};
         prev_q <= line;
         done   <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               if (prev_q && !line) begin
                  state_q <= RX_RUN;
                  tick_q  <= (div >> 1) - 1'b1;
                  idx_q   <= '0;
               end
            end
            RX_RUN: begin
               if (tick_q != '0) begin
                  tick_q <= tick_q - 1'b1;
               end else if (idx_q == '0 && line) begin
                  state_q <= RX_IDLE;   // start bit did not hold
               end else begin
                  shreg_q <= frame_w;
                  tick_q  <= div - 1'b1;
                  if (last_bit) begin
                     state_q <= RX_IDLE;
                     done    <= 1'b1;
                     data    <= frame_w[DATA_W:1];
                     ferr    <= ~&frame_w[FRAME_W-1:DATA_W+1];
                     brk     <= ~|frame_w;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sio_uart_mm.sv
module sio_uart_mm #(
   parameter int DIV_W       = 16,
   parameter int DEF_DIV     = 434,
   parameter int HAS_DIV_REG = 1,
   parameter int DATA_W      = 8,
   parameter int STOP_W      = 2,
   parameter int BUS_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       addr,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             txd,
   input  logic             rxd,
   output logic             irq
);
   import sio_pkg::*;

   if (DEF_DIV < MIN_DIV || DEF_DIV >= (1 << DIV_W)) begin : g_bad_div
      $error("DEF_DIV out of range for DIV_W");
   end
   if (BUS_W < NFLAG || BUS_W < DIV_W || BUS_W < DATA_W) begin : g_bad_bus
      $error("BUS_W too narrow");
   end
   if (HAS_DIV_REG != 0 && HAS_DIV_REG != 1) begin : g_bad_opt
      $error("HAS_DIV_REG must be 0 or 1");
   end

   logic             wr_stat, wr_txd, rd_rxd;
   logic [DIV_W-1:0] div_q, div_eff;
   logic [NFLAG-1:0] ctrl_q, status_w;
   logic [DATA_W-1:0] rx_data_q, rx_byte;
   logic             rrdy_q, roe_q, toe_q, fe_q, brk_q;
   logic             trdy, tmt, rx_done, rx_fe, rx_brk;

   assign wr_stat = wr_en && addr == REG_STAT;
   assign wr_txd  = wr_en && addr == REG_TXD;
   assign rd_rxd  = rd_en && addr == REG_RXD;

   if (HAS_DIV_REG == 1) begin : g_div_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     div_q <= DIV_W'(DEF_DIV);
         else if (wr_en && addr == REG_DIV) div_q <= wdata[DIV_W-1:0];
      end
   end else begin : g_div_const
      assign div_q = DIV_W'(DEF_DIV);
   end

   assign div_eff = (div_q < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_q;

   sio_tx #(.DATA_W(DATA_W), .STOP_W(STOP_W), .DIV_W(DIV_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .div(div_eff),
      .load(wr_txd && trdy), .ld_data(wdata[DATA_W-1:0]),
      .hold_empty(trdy), .idle(tmt), .txd(txd)
   );

   sio_rx #(.DATA_W(DATA_W), .STOP_W(STOP_W), .DIV_W(DIV_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .div(div_eff), .rxd(rxd),
      .done(rx_done), .data(rx_byte), .ferr(rx_fe), .brk(rx_brk)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data_q <= '0;
         rrdy_q    <= 1'b0;
         roe_q     <= 1'b0;
         toe_q     <= 1'b0;
         fe_q      <= 1'b0;
         brk_q     <= 1'b0;
         ctrl_q    <= '0;
      end else begin
         if (rx_done)      rx_data_q <= rx_byte;
         if (rx_done)      rrdy_q <= 1'b1;
         else if (rd_rxd)  rrdy_q <= 1'b0;
         // a new error event wins over a clearing write in the same cycle
         if (rx_done && rrdy_q && !rd_rxd) roe_q <= 1'b1;
         else if (wr_stat)                  roe_q <= 1'b0;
         if (rx_done && rx_fe)              fe_q  <= 1'b1;
         else if (wr_stat)                  fe_q  <= 1'b0;
         if (rx_done && rx_brk)             brk_q <= 1'b1;
         else if (wr_stat)                  brk_q <= 1'b0;
         if (wr_txd && !trdy)               toe_q <= 1'b1;
         else if (wr_stat)                  toe_q <= 1'b0;
         if (wr_en && addr == REG_CTRL)     ctrl_q <= wdata[NFLAG-1:0];
      end
   end

   always_comb begin
      status_w         = '0;
      status_w[F_PE]   = 1'b0;
      status_w[F_FE]   = fe_q;
      status_w[F_BRK]  = brk_q;
      status_w[F_ROE]  = roe_q;
      status_w[F_TOE]  = toe_q;
      status_w[F_TMT]  = tmt;
      status_w[F_TRDY] = trdy;
      status_w[F_RRDY] = rrdy_q;
      status_w[F_E]    = fe_q | brk_q | roe_q | toe_q;
   end

   assign irq = |(status_w & ctrl_q);

   always_comb begin
      unique case (addr)
         REG_RXD:  rdata = BUS_W'(rx_data_q);
         REG_STAT: rdata = BUS_W'(status_w);
         REG_CTRL: rdata = BUS_W'(ctrl_q);
         REG_DIV:  rdata = BUS_W'(div_q);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/sio_uart_mm_chk.sv
module sio_uart_mm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] addr,
   input logic       wr_en,
   input logic       rd_en,
   input logic       txd,
   input logic       irq,
   input logic [8:0] stat,
   input logic [8:0] ctrl,
   input logic       rx_done
);
   import sio_pkg::*;

   AST_TOE_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_TXD && !stat[F_TRDY]) |=> stat[F_TOE]); // R3

   AST_STAT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_STAT && !rx_done) |=>
         !stat[F_TOE] && !stat[F_ROE] && !stat[F_FE] && !stat[F_BRK] && !stat[F_E]); // R9

   AST_RXD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == REG_RXD && !rx_done) |=> !stat[F_RRDY]); // R5

   AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && stat[F_RRDY] && !(rd_en && addr == REG_RXD)) |=> stat[F_ROE]); // R6

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      stat[F_TMT] |-> txd); // R2

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == '0) |-> !irq); // R10
endmodule

bind sio_uart_mm sio_uart_mm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
   .txd(txd), .irq(irq), .stat(status_w), .ctrl(ctrl_q), .rx_done(rx_done)
);

// File: tb/sio_uart_mm_test.sv
module sio_uart_mm_test;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 16;

   logic        clk = 1'b0;
   logic        rst_n, wr_en, rd_en, rxd;
   logic [2:0]  addr;
   logic [15:0] wdata, rdata, rv;
   logic        txd, irq;
   int          checks = 0;
   int          fails  = 0;
   logic [7:0]  exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_uart_mm uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .irq(irq)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   // driver: send a character, expect it on the line if it should be accepted
   task automatic tx_send(input logic [7:0] b, input bit expect_sent);
      if (expect_sent) exp_q.push_back(b);
      bus_wr(3'd1, {8'h00, b});
   endtask

   task automatic rx_frame(input logic [7:0] b, input logic stop1, input logic stop2);
      logic [10:0] f;
      f = {stop2, stop1, b, 1'b0};
      for (int i = 0; i < 11; i++) begin
         @(negedge clk); rxd = f[i];
         repeat (DIV - 1) @(negedge clk);
      end
      @(negedge clk); rxd = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   // monitor: decode frames on txd and compare with the scoreboard queue (R2)
   initial begin
      logic [7:0] got;
      logic       st, sp1, sp2;
      wait (rst_n === 1'b1);
      forever begin
         @(negedge clk);
         if (txd === 1'b0) begin
            repeat (DIV/2) @(negedge clk);
            st = txd;
            for (int i = 0; i < 8; i++) begin
               repeat (DIV) @(negedge clk);
               got[i] = txd;
            end
            repeat (DIV) @(negedge clk); sp1 = txd;
            repeat (DIV) @(negedge clk); sp2 = txd;
            chk("R2 start bit low", {15'd0, st}, 16'h0000);
            chk("R2 stop bits high", {14'd0, sp2, sp1}, 16'h0003);
            if (exp_q.size() == 0) begin
               chk("R3 unexpected frame on txd", {8'h00, got}, 16'hFFFF);
            end else begin
               chk("R2 frame data", {8'h00, got}, {8'h00, exp_q.pop_front()});
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rxd = 1'b1; addr = '0; wdata = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_rd(3'd2, rv); chk("R1 status", rv, 16'h0060);
      bus_rd(3'd3, rv); chk("R1 control", rv, 16'h0000);
      bus_rd(3'd4, rv); chk("R1 divisor", rv, 16'd434);
      chk("R1 txd idle", {15'd0, txd}, 16'h0001);
      chk("R1 irq low", {15'd0, irq}, 16'h0000);

      // R11 divisor
      bus_wr(3'd4, 16'(DIV));
      bus_rd(3'd4, rv); chk("R11 divisor readback", rv, 16'(DIV));

      // R10 control readback and interrupt combining
      bus_wr(3'd3, 16'hFFFF);
      bus_rd(3'd3, rv); chk("R10 control keeps 9 bits", rv, 16'h01FF);
      bus_wr(3'd3, 16'h0040);
      chk("R10 irq from TRDY", {15'd0, irq}, 16'h0001);
      bus_wr(3'd3, 16'h0080);
      chk("R10 irq off, RRDY clear", {15'd0, irq}, 16'h0000);
      bus_wr(3'd3, 16'h0000);

      // R2 single character
      tx_send(8'hA5, 1'b1);
      bus_rd(3'd2, rv); chk("R2 TMT low while sending", rv, 16'h0040);
      wait (exp_q.size() == 0);
      repeat (2*DIV) @(negedge clk);
      bus_rd(3'd2, rv); chk("R2 TMT back high", rv, 16'h0060);

      // R3 write while holding register full
      tx_send(8'h3C, 1'b1);
      tx_send(8'hC3, 1'b1);
      tx_send(8'h77, 1'b0);
      bus_rd(3'd2, rv); chk("R3 TOE and E set", rv, 16'h0110);
      bus_wr(3'd2, 16'h0000);
      bus_rd(3'd2, rv); chk("R9 TOE cleared by status write", rv, 16'h0000);
      wait (exp_q.size() == 0);
      repeat (3*DIV) @(negedge clk);
      bus_rd(3'd2, rv); chk("R2 idle after two frames", rv, 16'h0060);

      // R4 / R5 reception
      rx_frame(8'h5A, 1'b1, 1'b1);
      bus_rd(3'd2, rv); chk("R4 RRDY set", rv, 16'h00E0);
      bus_wr(3'd3, 16'h0080);
      chk("R10 irq from RRDY", {15'd0, irq}, 16'h0001);
      bus_rd(3'd0, rv); chk("R4 received byte", rv, 16'h005A);
      bus_rd(3'd2, rv); chk("R5 RRDY cleared by read", rv, 16'h0060);
      chk("R10 irq drops", {15'd0, irq}, 16'h0000);
      bus_wr(3'd3, 16'h0000);

      // R6 overrun
      rx_frame(8'h11, 1'b1, 1'b1);
      rx_frame(8'h22, 1'b1, 1'b1);
      bus_rd(3'd2, rv); chk("R6 ROE set", rv, 16'h01E8);
      bus_wr(3'd2, 16'hFFFF);
      bus_rd(3'd2, rv); chk("R9 errors clear, RRDY kept", rv, 16'h00E0);
      bus_rd(3'd0, rv); chk("R6 newest byte kept", rv, 16'h0022);

      // R7 framing error on second stop bit
      rx_frame(8'h33, 1'b1, 1'b0);
      bus_rd(3'd2, rv); chk("R7 FE set", rv, 16'h01E2);
      chk("R12 PE reads zero", {15'd0, rv[0]}, 16'h0000);
      bus_rd(3'd0, rv); chk("R7 byte with bad stop", rv, 16'h0033);
      bus_wr(3'd2, 16'h1234);

      // R8 break
      @(negedge clk); rxd = 1'b0;
      repeat (12*DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (DIV) @(negedge clk);
      bus_rd(3'd2, rv); chk("R8 BRK and FE set", rv, 16'h01E6);
      bus_rd(3'd0, rv); chk("R8 break byte", rv, 16'h0000);
      bus_wr(3'd2, 16'h0000);
      bus_rd(3'd2, rv); chk("R9 all clear", rv, 16'h0060);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule